// File: doc/BRIEF.md
# Watchdog Timer with Independent Oscillator Tick

This block is a supervisor timer. A free-running up-counter advances on pulses from a separate low-frequency oscillator rather than on every system clock. Once enabled, software must zero the counter often enough. If the counter ever rolls past its all-ones value, the block raises a reset request for the rest of the chip. It also records that the watchdog caused the reset, so that boot code can tell a watchdog restart from a power-on or pin reset.

Software reaches the block through a small byte-wide register file: a control register, a key register and a status register. The control register is guarded by a key step. The key value must be written to the key register, and only the single control write that follows it takes effect. A runaway program that scribbles over the control register therefore cannot turn the watchdog off or keep feeding it. The analog oscillator sits outside the block. Its output arrives as a one-cycle pulse that is already synchronised into the system clock domain. The block drives an oscillator-run output so that the oscillator only runs while the watchdog is enabled.

Top module: `wdog_top`

## Requirements
- R1: After a synchronous reset, the control register reads 00h, the status register reads 00h, `wdt_rst_req` is 0 and `osc_run` is 0.
- R2: A write to the control register (address 0) that is not directly preceded by a key unlock has no effect. The control register read-back and `osc_run` keep their values.
- R3: Writing the KEY parameter to the key register (address 1) opens exactly one control write. After that write the lock is closed again, so a second control write is ignored. Writing any other value to the key register also closes the lock. Bit 0 of the key register reads 1 while the lock is open.
- R4: While enabled, the counter advances by one on each cycle in which `osc_tick` is 1. On the edge that samples tick number 2^CNT_W after a zeroing, the counter rolls over, and `wdt_rst_req` is 1 in the cycle after that edge.
- R5: On a rollover, `wdt_rst_req` stays 1 for exactly HOLD_CYC system clock cycles and then returns to 0.
- R6: A rollover clears the enable bit (control bit 7) and zeroes the counter. It also sets the watchdog-cause flag, which is bit 0 of the status register (address 2).
- R7: An accepted control write with bit 0 (clear) set zeroes the counter, and the next 2^CNT_W ticks are needed for a rollover. The clear wins over a tick in the same cycle. Bit 0 always reads back as 0.
- R8: A hardware reset clears the enable bit and the watchdog-cause flag.
- R9: While the enable bit is 0, ticks are ignored and the counter keeps its value. When the watchdog is enabled again without a clear, counting resumes from that value.
- R10: `osc_run` equals the enable bit, so the oscillator runs only while the watchdog is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| osc_tick | input | 1 | One-cycle pulse from the synchronised watchdog oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 key, 2 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| osc_run | output | 1 | Oscillator run request, equal to the enable bit |
| wdt_rst_req | output | 1 | Reset request, high for HOLD_CYC cycles after a rollover |

## Verification
Every state element updates on the edge that samples a write or a tick. The read port is combinational, so a register write is visible on `rd_data` one clock edge after the write cycle. Likewise, `wdt_rst_req` is high in the cycle right after the edge that samples the rollover tick, and it stays high for HOLD_CYC cycles. The bench drives every input on the falling edge and samples on the next falling edge. A tick or write is therefore always judged after exactly one rising edge, and the length of the request pulse is counted one sample per cycle. The tick sweep runs over a 4-bit counter. It places the clear write after every possible tick count, and for odd counts it also puts a tick in the same cycle as the clear write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_KEY  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int EN_BIT    = 7;
    localparam int CLR_BIT   = 0;
    localparam int CAUSE_BIT = 0;
    localparam int OPEN_BIT  = 0;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
        logic [7:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic en;
        logic open;
        logic clr;
    } ctrl_state_t;

    function automatic logic [7:0] ctrl_image(input logic en);
        logic [7:0] b;
        b = 8'h00;
        b[EN_BIT] = en;
        return b;
    endfunction

    function automatic logic [7:0] flag_image(input logic flag, input int pos);
        logic [7:0] b;
        b = 8'h00;
        b[pos] = flag;
        return b;
    endfunction

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter logic [7:0] KEY = 8'hA5
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_wr_t     wr,
    input  logic        ovf,
    output ctrl_state_t st
);

    logic en_q;
    logic open_q;
    logic take_ctrl;
    logic key_hit;

    assign take_ctrl = wr.valid && (wr.sel == SEL_CTRL) && open_q;
    assign key_hit   = wr.valid && (wr.sel == SEL_KEY);

    always_ff @(posedge clk) begin
        if (rst || ovf) begin
            en_q <= 1'b0;
        end else if (take_ctrl) begin
            en_q <= wr.data[EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ovf) begin
            open_q <= 1'b0;
        end else if (key_hit) begin
            open_q <= (wr.data == KEY);
        end else if (take_ctrl) begin
            open_q <= 1'b0;
        end
    end

    always_comb begin
        st.en   = en_q;
        st.open = open_q;
        st.clr  = take_ctrl && wr.data[CLR_BIT];
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             zero,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic step;

    assign step = run && tick;
    assign ovf  = step && !zero && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst || zero || ovf) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
    parameter int HOLD_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic ovf,
    output logic req,
    output logic cause
);

    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (ovf) begin
            left_q <= HW'(HOLD_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause <= 1'b0;
        end else if (ovf) begin
            cause <= 1'b1;
        end
    end

    assign req = (left_q != '0);

endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int         CNT_W    = 16,
    parameter int         HOLD_CYC = 32,
    parameter logic [7:0] KEY      = 8'hA5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       osc_run,
    output logic       wdt_rst_req
);

    bus_wr_t          wr;
    ctrl_state_t      st;
    logic             ovf;
    logic             cause_q;
    logic [CNT_W-1:0] count;

    assign wr.valid = wr_en;
    assign wr.sel   = reg_sel_e'(wr_addr);
    assign wr.data  = wr_data;

    wdog_ctrl #(.KEY(KEY)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .wr  (wr),
        .ovf (ovf),
        .st  (st)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (st.en),
        .tick  (osc_tick),
        .zero  (st.clr),
        .count (count),
        .ovf   (ovf)
    );

    wdog_rstgen #(.HOLD_CYC(HOLD_CYC)) u_rgen (
        .clk   (clk),
        .rst   (rst),
        .ovf   (ovf),
        .req   (wdt_rst_req),
        .cause (cause_q)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data = ctrl_image(st.en);
            SEL_KEY:  rd_data = flag_image(st.open, OPEN_BIT);
            SEL_STAT: rd_data = flag_image(cause_q, CAUSE_BIT);
            default:  rd_data = 8'h00;
        endcase
    end

    assign osc_run = st.en;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int CNT_W    = 16,
    parameter int HOLD_CYC = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             osc_tick,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             wr_clr,
    input logic             en,
    input logic             unlocked,
    input logic [CNT_W-1:0] count,
    input logic             req,
    input logic             cause
);

    localparam int RW = $clog2(HOLD_CYC + 2);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [RW-1:0] run_len;
    logic          ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == 2'd0);

    always_ff @(posedge clk) begin
        if (rst || !req) run_len <= '0;
        else             run_len <= run_len + 1'b1;
    end

    AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && !unlocked && !(en && osc_tick && count == TOP) |=> en == $past(en)); // R2

    AST_UNLOCK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && unlocked |=> !unlocked); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        en && osc_tick && !(ctrl_wr && unlocked && wr_clr) && count != TOP
        |=> count == CNT_W'($past(count) + 1'b1)); // R4

    AST_REQ_HOLD_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(req) && !$past(rst) |-> run_len == RW'(HOLD_CYC)); // R5

    AST_ROLLOVER_EFFECTS: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> !en && cause && count == '0); // R6

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en && !(ctrl_wr && unlocked) |=> $stable(count)); // R9

endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_clr   (wr_data[0]),
    .en       (st.en),
    .unlocked (st.open),
    .count    (count),
    .req      (wdt_rst_req),
    .cause    (cause_q)
);

// File: tb/wdog_top_tb.sv
module wdog_top_tb;

    localparam int         CNT_W = 4;
    localparam int         HOLD  = 3;
    localparam logic [7:0] KEY   = 8'h5A;
    localparam int         SPAN  = 1 << CNT_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       osc_run;
    logic       wdt_rst_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    wdog_top #(.CNT_W(CNT_W), .HOLD_CYC(HOLD), .KEY(KEY)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .osc_tick    (osc_tick),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .osc_run     (osc_run),
        .wdt_rst_req (wdt_rst_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic t);
        wr_en = 1'b1; wr_addr = a; wr_data = d; osc_tick = t;
        @(negedge clk);
        wr_en = 1'b0; osc_tick = 1'b0;
    endtask

    task automatic tick1();
        osc_tick = 1'b1;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    // n ticks, with an idle cycle before every third one; request must stay low
    task automatic ticks_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            if (i % 3 == 2) @(negedge clk);
            tick1();
            chk(tag, int'(wdt_rst_req), 0);
        end
    endtask

    // count high cycles of the request; the first high sample is already taken
    task automatic hold_len(input string tag);
        int len = 1;
        for (int i = 0; i < HOLD + 4; i++) begin
            @(negedge clk);
            if (wdt_rst_req) len++;
        end
        chk(tag, len, HOLD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 8'h00);
        rd_chk("R1 status", 2'd2, 8'h00);
        chk("R1 req", int'(wdt_rst_req), 0);
        chk("R1 osc_run", int'(osc_run), 0);

        // R2 locked control write ignored
        wr(2'd0, 8'h80, 1'b0);
        rd_chk("R2 ctrl", 2'd0, 8'h00);
        chk("R2 osc_run", int'(osc_run), 0);

        // R9 ticks while disabled never roll over
        ticks_quiet(SPAN + 5, "R9 disabled ticks");

        // R3 key then one write
        wr(2'd1, KEY, 1'b0);
        rd_chk("R3 lock open", 2'd1, 8'h01);
        wr(2'd0, 8'h80, 1'b0);
        rd_chk("R3 ctrl", 2'd0, 8'h80);
        rd_chk("R3 lock closed", 2'd1, 8'h00);
        chk("R10 osc_run on", int'(osc_run), 1);
        wr(2'd0, 8'h00, 1'b0);
        rd_chk("R3 second write", 2'd0, 8'h80);
        wr(2'd1, KEY ^ 8'h01, 1'b0);
        wr(2'd0, 8'h00, 1'b0);
        rd_chk("R3 wrong key", 2'd0, 8'h80);
        wr(2'd1, KEY, 1'b0);
        wr(2'd1, 8'h00, 1'b0);
        wr(2'd0, 8'h00, 1'b0);
        rd_chk("R3 relock by bad key", 2'd0, 8'h80);

        // R4 rollover after SPAN ticks
        ticks_quiet(SPAN - 1, "R4 before rollover");
        tick1();
        chk("R4 rollover req", int'(wdt_rst_req), 1);
        rd_chk("R6 enable cleared", 2'd0, 8'h00);
        rd_chk("R6 cause set", 2'd2, 8'h01);
        chk("R10 osc_run off", int'(osc_run), 0);
        hold_len("R5 hold length");

        // R7 clear sweep over every tick position
        for (int p = 0; p < SPAN; p++) begin
            wr(2'd1, KEY, 1'b0);
            wr(2'd0, 8'h80, 1'b0);
            ticks_quiet(p, "R7 pre-clear");
            wr(2'd1, KEY, 1'b0);
            wr(2'd0, 8'h81, p[0]);
            rd_chk("R7 clear reads 0", 2'd0, 8'h80);
            ticks_quiet(SPAN - 1, "R7 after clear");
            tick1();
            chk("R7 rollover after clear", int'(wdt_rst_req), 1);
            hold_len("R5 hold in sweep");
        end

        // R9 pause and resume keeps count
        wr(2'd1, KEY, 1'b0);
        wr(2'd0, 8'h80, 1'b0);
        ticks_quiet(10, "R9 first part");
        wr(2'd1, KEY, 1'b0);
        wr(2'd0, 8'h00, 1'b0);
        ticks_quiet(20, "R9 paused");
        wr(2'd1, KEY, 1'b0);
        wr(2'd0, 8'h80, 1'b0);
        ticks_quiet(SPAN - 11, "R9 resumed");
        tick1();
        chk("R9 resumed rollover", int'(wdt_rst_req), 1);
        repeat (HOLD + 2) @(negedge clk);

        // R8 hardware reset clears enable and cause
        wr(2'd1, KEY, 1'b0);
        wr(2'd0, 8'h80, 1'b0);
        rd_chk("R8 cause before reset", 2'd2, 8'h01);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk("R8 cause cleared", 2'd2, 8'h00);
        rd_chk("R8 enable cleared", 2'd0, 8'h00);
        chk("R8 req low", int'(wdt_rst_req), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule